// File: doc/BRIEF.md
# Nine-bit multidrop address filter

This block sits between a UART character receiver and the receive FIFO on a multidrop (RS-485) line that uses nine-bit characters. Each received character arrives with eight data bits, a ninth bit and a one-cycle valid strobe. A ninth bit of 1 marks an address character and a ninth bit of 0 marks a data character. For each character the block decides whether to push it into the FIFO. It stores the ninth bit in the error-flag position next to the data. When an address character is stored and the line-status interrupt is enabled, it raises an interrupt request.

The block holds a receiver-enable state. The host can set it or clear it with one-cycle strobes. In host-managed mode every address character is stored for software to inspect, and only the host changes the enable. In automatic mode the block compares each address character with a programmed address byte:

- A match turns the receiver on, and the address character is stored.
- A mismatch turns the receiver off, and the address character is discarded.

In both modes, data characters pass only while the receiver is enabled.

Top module: `mdf_addr_filter`

## Requirements
- R1: A character with ninth bit 1 is an address character and one with ninth bit 0 is a data character. Every character pushed into the FIFO carries its ninth bit on `fifo_flag_o` and its eight data bits on `fifo_data_o`.
- R2: In host-managed mode (`auto_mode_i` = 0), a data character is dropped while the receiver is disabled and is pushed while it is enabled.
- R3: In host-managed mode, an address character is always pushed, with flag 1, whatever the enable state.
- R4: In host-managed mode, received characters never change the receiver-enable state; only host strobes do.
- R5: In automatic mode (`auto_mode_i` = 1), a data character is dropped while the receiver is disabled and is pushed while it is enabled.
- R6: In automatic mode, an address character equal to `match_addr_i` is pushed with flag 1 and leaves the receiver enabled, whether or not it was enabled before.
- R7: In automatic mode, an address character different from `match_addr_i` is discarded and leaves the receiver disabled.
- R8: `host_en_set_i` enables the receiver and `host_en_clr_i` disables it from the next cycle. When both are high in the same cycle, the clear wins (default `CLR_WINS` = 1).
- R9: A host strobe in the same cycle as an automatic enable change decides the new enable state. The character's own store decision is unchanged by the strobe.
- R10: `lsi_req_o` is a one-cycle pulse that comes with each stored address character when `lsi_en_i` was high in the character's valid cycle. It is never high at any other time.
- R11: During and right after reset, the receiver is disabled and there is no push and no interrupt request.
- R12: With `OUT_STAGE` = 1, the push, data, flag and interrupt outputs appear exactly one cycle after the valid strobe. The store decision uses the enable state as it was in the valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a character has been received |
| rx_data_i | input | DATA_W | Received data bits |
| rx_addr_flag_i | input | 1 | Ninth bit: 1 for an address character |
| auto_mode_i | input | 1 | 1 selects automatic address matching |
| match_addr_i | input | DATA_W | Programmed station address |
| host_en_set_i | input | 1 | Host strobe that enables the receiver |
| host_en_clr_i | input | 1 | Host strobe that disables the receiver |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| fifo_push_o | output | 1 | Write strobe for the receive FIFO |
| fifo_data_o | output | DATA_W | Data to be written into the FIFO |
| fifo_flag_o | output | 1 | Error-flag bit stored with the data (the ninth bit) |
| lsi_req_o | output | 1 | Line-status interrupt request pulse |
| rx_enabled_o | output | 1 | Current receiver-enable state |

## Verification
The bench builds the block with `DATA_W` = 8, `OUT_STAGE` = 1 and `CLR_WINS` = 1. These values exercise the one-cycle output latency and the rule that a store decision uses the enable state from before the update. They also cover the case where set and clear arrive together and the clear wins. A behavioural model predicts every output on every cycle. The stimulus includes host strobes in the same cycle as matching and non-matching address characters, back-to-back characters, and address characters with the interrupt enable both high and low.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
   typedef enum logic [1:0] {
      V_DROP       = 2'd0,
      V_STORE      = 2'd1,
      V_STORE_ADDR = 2'd2
   } verdict_e;

   typedef enum logic [1:0] {
      EN_HOLD = 2'd0,
      EN_SET  = 2'd1,
      EN_CLR  = 2'd2
   } en_req_e;
endpackage

// File: rtl/mdf_classify.sv
module mdf_classify
   import mdf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              addr_flag_i,
   input  logic              auto_mode_i,
   input  logic [DATA_W-1:0] match_addr_i,
   input  logic              rx_en_i,
   output verdict_e          verdict_o,
   output en_req_e           auto_req_o
);
   logic hit;
   assign hit = (data_i == match_addr_i);

   always_comb begin
      verdict_o  = V_DROP;
      auto_req_o = EN_HOLD;
      if (valid_i) begin
         if (addr_flag_i) begin
            if (!auto_mode_i) begin
               verdict_o = V_STORE_ADDR;
            end else if (hit) begin
               verdict_o  = V_STORE_ADDR;
               auto_req_o = EN_SET;
            end else begin
               auto_req_o = EN_CLR;
            end
         end else if (rx_en_i) begin
            verdict_o = V_STORE;
         end
      end
   end
endmodule

// File: rtl/mdf_enable_ctl.sv
module mdf_enable_ctl
   import mdf_pkg::*;
#(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    host_set_i,
   input  logic    host_clr_i,
   input  en_req_e auto_req_i,
   output logic    rx_en_o
);
   en_req_e host_req;
   en_req_e final_req;

   generate
      if (CLR_WINS) begin : g_clr_first
         always_comb begin
            if (host_clr_i)      host_req = EN_CLR;
            else if (host_set_i) host_req = EN_SET;
            else                 host_req = EN_HOLD;
         end
      end else begin : g_set_first
         always_comb begin
            if (host_set_i)      host_req = EN_SET;
            else if (host_clr_i) host_req = EN_CLR;
            else                 host_req = EN_HOLD;
         end
      end
   endgenerate

   assign final_req = (host_req != EN_HOLD) ? host_req : auto_req_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en_o <= 1'b0;
      end else begin
         case (final_req)
            EN_SET:  rx_en_o <= 1'b1;
            EN_CLR:  rx_en_o <= 1'b0;
            default: rx_en_o <= rx_en_o;
         endcase
      end
   end
endmodule

// File: rtl/mdf_out_stage.sv
module mdf_out_stage #(
   parameter int DATA_W    = 8,
   parameter int OUT_STAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              flag_i,
   input  logic              irq_i,
   output logic              push_o,
   output logic [DATA_W-1:0] data_o,
   output logic              flag_o,
   output logic              irq_o
);
   generate
      if (OUT_STAGE != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               push_o <= 1'b0;
               data_o <= '0;
               flag_o <= 1'b0;
               irq_o  <= 1'b0;
            end else begin
               push_o <= push_i;
               data_o <= data_i;
               flag_o <= flag_i;
               irq_o  <= irq_i;
            end
         end
      end else begin : g_pass
         assign push_o = push_i;
         assign data_o = data_i;
         assign flag_o = flag_i;
         assign irq_o  = irq_i;
      end
   endgenerate
endmodule

// File: rtl/mdf_addr_filter.sv
module mdf_addr_filter
   import mdf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OUT_STAGE = 1,
   parameter bit CLR_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_addr_flag_i,
   input  logic              auto_mode_i,
   input  logic [DATA_W-1:0] match_addr_i,
   input  logic              host_en_set_i,
   input  logic              host_en_clr_i,
   input  logic              lsi_en_i,
   output logic              fifo_push_o,
   output logic [DATA_W-1:0] fifo_data_o,
   output logic              fifo_flag_o,
   output logic              lsi_req_o,
   output logic              rx_enabled_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mdf_addr_filter: DATA_W must be at least 1");
      end
      if (OUT_STAGE != 0 && OUT_STAGE != 1) begin : g_bad_stage
         $error("mdf_addr_filter: OUT_STAGE must be 0 or 1");
      end
   endgenerate

   verdict_e verdict;
   en_req_e  auto_req;
   logic     rx_en;
   logic     push_c;
   logic     irq_c;

   mdf_classify #(.DATA_W(DATA_W)) i_classify (
      .valid_i      (rx_valid_i),
      .data_i       (rx_data_i),
      .addr_flag_i  (rx_addr_flag_i),
      .auto_mode_i  (auto_mode_i),
      .match_addr_i (match_addr_i),
      .rx_en_i      (rx_en),
      .verdict_o    (verdict),
      .auto_req_o   (auto_req)
   );

   mdf_enable_ctl #(.CLR_WINS(CLR_WINS)) i_enable (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_set_i (host_en_set_i),
      .host_clr_i (host_en_clr_i),
      .auto_req_i (auto_req),
      .rx_en_o    (rx_en)
   );

   assign push_c = (verdict != V_DROP);
   assign irq_c  = (verdict == V_STORE_ADDR) && lsi_en_i;

   mdf_out_stage #(.DATA_W(DATA_W), .OUT_STAGE(OUT_STAGE)) i_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push_c),
      .data_i (rx_data_i),
      .flag_i (rx_addr_flag_i),
      .irq_i  (irq_c),
      .push_o (fifo_push_o),
      .data_o (fifo_data_o),
      .flag_o (fifo_flag_o),
      .irq_o  (lsi_req_o)
   );

   assign rx_enabled_o = rx_en;
endmodule

// File: rtl/mdf_addr_filter_chk.sv
module mdf_addr_filter_chk #(
   parameter int DATA_W    = 8,
   parameter int OUT_STAGE = 1,
   parameter bit CLR_WINS  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid_i,
   input logic [DATA_W-1:0] rx_data_i,
   input logic              rx_addr_flag_i,
   input logic              auto_mode_i,
   input logic [DATA_W-1:0] match_addr_i,
   input logic              host_en_set_i,
   input logic              host_en_clr_i,
   input logic              lsi_en_i,
   input logic              fifo_push_o,
   input logic [DATA_W-1:0] fifo_data_o,
   input logic              fifo_flag_o,
   input logic              lsi_req_o,
   input logic              rx_enabled_o
);
   // inputs aligned with the cycle in which their outputs appear
   logic d_valid, d_flag, d_auto, d_en, d_lsi;

   generate
      if (OUT_STAGE != 0) begin : g_delay
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_valid <= 1'b0;
               d_flag  <= 1'b0;
               d_auto  <= 1'b0;
               d_en    <= 1'b0;
               d_lsi   <= 1'b0;
            end else begin
               d_valid <= rx_valid_i;
               d_flag  <= rx_addr_flag_i;
               d_auto  <= auto_mode_i;
               d_en    <= rx_enabled_o;
               d_lsi   <= lsi_en_i;
            end
         end
      end else begin : g_live
         assign d_valid = rx_valid_i;
         assign d_flag  = rx_addr_flag_i;
         assign d_auto  = auto_mode_i;
         assign d_en    = rx_enabled_o;
         assign d_lsi   = lsi_en_i;
      end
   endgenerate

   p_flag_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push_o |-> (fifo_flag_o == d_flag));

   p_norm_data_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_auto && !d_flag && !d_en) |-> !fifo_push_o);

   p_norm_addr_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_auto && d_flag) |-> fifo_push_o);

   p_norm_en_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_mode_i && !host_en_set_i && !host_en_clr_i) |=> $stable(rx_enabled_o));

   p_auto_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && d_auto && !d_flag) |-> (fifo_push_o == d_en));

   p_auto_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && auto_mode_i && rx_addr_flag_i && (rx_data_i == match_addr_i)
       && !host_en_clr_i) |=> rx_enabled_o);

   p_auto_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && auto_mode_i && rx_addr_flag_i && (rx_data_i != match_addr_i)
       && !host_en_set_i) |=> !rx_enabled_o);

   p_host_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en_set_i && (!host_en_clr_i || !CLR_WINS)) |=> rx_enabled_o);

   p_host_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en_clr_i && (!host_en_set_i || CLR_WINS)) |=> !rx_enabled_o);

   p_host_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && auto_mode_i && rx_addr_flag_i && host_en_clr_i && !host_en_set_i)
      |=> !rx_enabled_o);

   p_irq_only_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lsi_req_o |-> (fifo_push_o && fifo_flag_o && d_lsi));

   p_irq_each_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push_o && fifo_flag_o && d_lsi) |-> lsi_req_o);

   p_push_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |-> !fifo_push_o);
endmodule

bind mdf_addr_filter mdf_addr_filter_chk #(
   .DATA_W    (DATA_W),
   .OUT_STAGE (OUT_STAGE),
   .CLR_WINS  (CLR_WINS)
) i_chk (.*);

// File: tb/test_mdf_addr_filter.sv
`timescale 1ns/1ps
module test_mdf_addr_filter;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_addr = 1'b0;
   logic          auto_mode = 1'b0;
   logic [DW-1:0] match_addr = 8'h42;
   logic          host_set = 1'b0;
   logic          host_clr = 1'b0;
   logic          lsi_en = 1'b0;
   logic          fifo_push;
   logic [DW-1:0] fifo_data;
   logic          fifo_flag;
   logic          lsi_req;
   logic          rx_enabled;

   int n_checks = 0;
   int n_fail   = 0;
   bit m_en     = 1'b0;

   always #2.5 clk = ~clk;

   mdf_addr_filter #(.DATA_W(DW), .OUT_STAGE(1), .CLR_WINS(1'b1)) i_mdf_addr_filter (
      .clk            (clk),
      .rst_n          (rst_n),
      .rx_valid_i     (rx_valid),
      .rx_data_i      (rx_data),
      .rx_addr_flag_i (rx_addr),
      .auto_mode_i    (auto_mode),
      .match_addr_i   (match_addr),
      .host_en_set_i  (host_set),
      .host_en_clr_i  (host_clr),
      .lsi_en_i       (lsi_en),
      .fifo_push_o    (fifo_push),
      .fifo_data_o    (fifo_data),
      .fifo_flag_o    (fifo_flag),
      .lsi_req_o      (lsi_req),
      .rx_enabled_o   (rx_enabled)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one character cycle: drive at negedge, model predicts, compare at the next negedge
   task automatic step(input bit v, input logic [DW-1:0] d, input bit a, input bit au,
                       input bit st, input bit cl, input bit le, input string tag);
      bit e_push, e_irq, nxt;
      rx_valid = v; rx_data = d; rx_addr = a; auto_mode = au;
      host_set = st; host_clr = cl; lsi_en = le;
      e_push = 1'b0; e_irq = 1'b0; nxt = m_en;
      if (v) begin
         if (a) begin
            if (!au || d == match_addr) begin
               e_push = 1'b1;
               e_irq  = le;
               if (au) nxt = 1'b1;
            end else begin
               nxt = 1'b0;
            end
         end else begin
            e_push = m_en;
         end
      end
      if (cl)      nxt = 1'b0;
      else if (st) nxt = 1'b1;
      m_en = nxt;
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0; host_set = 1'b0; host_clr = 1'b0;
      chk(tag, "push", int'(fifo_push), int'(e_push));
      chk(tag, "irq", int'(lsi_req), int'(e_irq));
      chk(tag, "enable", int'(rx_enabled), int'(m_en));
      if (e_push) begin
         chk(tag, "data", int'(fifo_data), int'(d));
         chk(tag, "flag", int'(fifo_flag), int'(a));
      end
   endtask

   task automatic idle(input string tag);
      step(1'b0, 8'h00, 1'b0, auto_mode, 1'b0, 1'b0, lsi_en, tag);
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", "push", int'(fifo_push), 0);
      chk("R11", "irq", int'(lsi_req), 0);
      chk("R11", "enable", int'(rx_enabled), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "enable after release", int'(rx_enabled), 0);
      chk("R11", "push after release", int'(fifo_push), 0);

      // host-managed mode
      step(1, 8'h11, 0, 0, 0, 0, 1, "R2");   // data dropped while disabled
      step(1, 8'h5A, 1, 0, 0, 0, 1, "R3");   // address stored, irq, enable unchanged (R4)
      step(1, 8'h22, 0, 0, 0, 0, 1, "R4");   // still disabled after address
      step(0, 8'h00, 0, 0, 1, 0, 1, "R8");   // host set
      step(1, 8'h33, 0, 0, 0, 0, 1, "R2");   // data stored while enabled
      step(1, 8'h34, 0, 0, 0, 0, 1, "R12");  // back-to-back data
      step(1, 8'hA5, 1, 0, 0, 0, 0, "R10");  // address stored, no irq when disabled intr
      step(1, 8'h42, 1, 0, 0, 0, 1, "R4");   // match value ignored in host mode
      step(0, 8'h00, 0, 0, 0, 1, 1, "R8");   // host clear
      step(1, 8'h35, 0, 0, 0, 0, 1, "R2");   // dropped again
      step(0, 8'h00, 0, 0, 1, 1, 1, "R8");   // set and clear together: clear wins
      step(1, 8'h01, 1, 0, 1, 0, 1, "R12");  // decision uses enable before the set
      step(1, 8'h02, 0, 0, 0, 0, 1, "R2");
      step(0, 8'h00, 0, 0, 0, 1, 1, "R8");

      // automatic mode
      step(1, 8'h44, 0, 1, 0, 0, 1, "R5");   // data dropped while disabled
      step(1, 8'h13, 1, 1, 0, 0, 1, "R7");   // non-matching address dropped
      step(1, 8'h42, 1, 1, 0, 0, 1, "R6");   // match: stored, enabled
      step(1, 8'h55, 0, 1, 0, 0, 1, "R5");   // data stored
      step(1, 8'h42, 1, 1, 0, 0, 0, "R6");   // match again, no irq with intr off (R10)
      step(1, 8'h56, 0, 1, 0, 0, 1, "R5");
      step(1, 8'h99, 1, 1, 0, 0, 1, "R7");   // mismatch: dropped and disabled
      step(1, 8'h57, 0, 1, 0, 0, 1, "R5");   // dropped
      step(1, 8'h42, 1, 1, 0, 1, 1, "R9");   // match with host clear: stored, stays off
      step(1, 8'h58, 0, 1, 0, 0, 1, "R9");   // dropped since disabled
      step(0, 8'h00, 0, 1, 1, 0, 1, "R8");
      step(1, 8'h77, 1, 1, 1, 0, 1, "R9");   // mismatch with host set: stays on
      step(1, 8'h59, 0, 1, 0, 0, 1, "R9");   // stored
      step(1, 8'h42, 1, 1, 0, 0, 1, "R12");  // back-to-back address and data
      step(1, 8'h5B, 0, 1, 0, 0, 1, "R12");
      step(1, 8'hC2, 1, 1, 0, 0, 1, "R7");   // differs in one bit
      idle("R10");                            // no stray irq or push
      step(1, 8'h42, 1, 1, 0, 0, 1, "R6");   // enable from disabled
      idle("R1");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule